// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a memory-mapped watchdog. It counts ticks from one of four tick inputs. If software does not restart the count in time, it raises a sticky reset request. The count is restarted by a refresh command. Refresh commands and configuration access are both guarded by fixed command words written to the counter register. Depending on a control bit, a command is either two 16-bit writes in sequence or a single 32-bit write.

A valid unlock sequence opens a short window. During that window the control/status, timeout and window registers accept writes. The window closes after a fixed number of bus clocks, or at the first control/status write, whichever comes first. Software can tell that the unlock took effect from an unlocked bit, and that its configuration was accepted from a reconfigured bit. An interrupt gives early warning a few ticks before the timeout. An optional window threshold makes a refresh that comes too early count as a failure.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the registers read as follows. Control/status at 0x0 reads 0x0000_0420, which means the update-permit bit (bit 5) and the reconfigured bit (bit 10) are set. Counter at 0x4 reads 0. Timeout at 0x8 reads 0xFFFF. Window at 0xC reads 0. The reset and interrupt outputs are low.
- R2: In 16-bit command mode (bit 13 = 0), unlock is the word 0xC520 written to 0x4, followed by 0xD928 as the very next bus write. The unlocked bit (bit 11) then reads 1 and bit 10 reads 0. Any other order, a different value, or an intervening write to another register leaves the block locked. Words with nonzero upper halves do nothing.
- R3: In 32-bit command mode (bit 13 = 1), refresh is the single word 0xB480A602 and unlock is the single word 0xD928C520. The 16-bit sequences have no effect in this mode.
- R4: Writes to 0x0, 0x8 and 0xC are ignored while the block is locked. The lock closes again at a control/status write, which also sets bit 10. Without such a write, it closes UNLOCK_CYCLES bus clocks after the unlock.
- R5: While bit 7 is set, the counter advances on each pulse of tick_in[src], where src is bits 9:8. Pulses on the other tick inputs are ignored.
- R6: A valid refresh sets the counter to 0. In 16-bit mode, refresh is 0xA602 followed by 0xB480.
- R7: When the counter reaches the timeout value, bit 14 is set and wdog_rst_o rises. wdog_rst_o then stays high, and the counter stays frozen, until rst_n. Refresh commands are ignored in this state.
- R8: irq_o is high when bit 6 is set and either bit 14 is set, or counting is enabled and counter + WARN_TICKS >= timeout.
- R9: Writing 1 to bit 14 clears the timeout flag at any time, locked or not. This does not release wdog_rst_o.
- R10: If the window register is nonzero and a refresh arrives while counter < window, the refresh is treated as a timeout (R7).
- R11: If bit 5 was written as 0, unlock sequences are rejected until rst_n.
- R12: With bit 12 set, the counter advances once per PRE_DIV selected ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_in | input | 4 | Tick pulses, one per clock source |
| irq_o | output | 1 | Early-warning interrupt |
| wdog_rst_o | output | 1 | Sticky reset request |

## Verification
A table of two-word sequences in 16-bit mode is driven from reset. The table covers the correct unlock pair, the pair reversed, a refresh pair, a repeated first word, and mixed halves, so that only the exact ordered pair opens the lock. Directed runs then compare the following pairs of cases:
- a refresh inside the window against one before it;
- 16-bit against 32-bit command words in each mode;
- ticks on the selected source against ticks on another source;
- a prescaled count against a direct count.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int UNLOCK_CYCLES = 128,
  parameter int PRE_DIV       = 256,
  parameter int WARN_TICKS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  tick_in,
  output logic        irq_o,
  output logic        wdog_rst_o
);
  localparam int WCW = $clog2(UNLOCK_CYCLES + 1);
  localparam int PW  = $clog2(PRE_DIV);
  localparam logic [3:0]  A_CS = 4'h0, A_CNT = 4'h4, A_TOV = 4'h8, A_WIN = 4'hC;
  localparam logic [15:0] REF_LO = 16'hA602, REF_HI = 16'hB480;
  localparam logic [15:0] UNL_LO = 16'hC520, UNL_HI = 16'hD928;

  logic cmd32, pres, en, ie, upd, flg, ulk, rcs;
  logic [1:0]     src, half;
  logic [15:0]    cnt, toval, win;
  logic [WCW-1:0] wleft;
  logic [PW-1:0]  pre_cnt;

  wire cnt_wr = bus_we && bus_addr == A_CNT;
  wire cs_any = bus_we && bus_addr == A_CS;
  wire cs_wr  = cs_any && ulk;
  wire is_ref = cnt_wr && (cmd32 ? bus_wdata == {REF_HI, REF_LO}
                                 : half == 2'd1 && bus_wdata == {16'h0, REF_HI});
  wire is_unl = cnt_wr && (cmd32 ? bus_wdata == {UNL_HI, UNL_LO}
                                 : half == 2'd2 && bus_wdata == {16'h0, UNL_HI});
  wire refresh_ok = is_ref && !wdog_rst_o;
  wire early      = refresh_ok && win != 16'h0 && cnt < win;
  wire unlock_ok  = is_unl && upd;
  wire sel_tick   = tick_in[src];
  wire pre_wrap   = pre_cnt == PW'(PRE_DIV - 1);
  wire step       = en && sel_tick && (!pres || pre_wrap) && !wdog_rst_o;
  wire expire     = step && ({1'b0, cnt} + 17'd1 >= {1'b0, toval});
  wire near       = {1'b0, cnt} + 17'(WARN_TICKS) >= {1'b0, toval};

  assign irq_o = ie && (flg || (en && near));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 2'd0;
    else if (bus_we) begin
      if (!cmd32 && cnt_wr && bus_wdata == {16'h0, REF_LO})      half <= 2'd1;
      else if (!cmd32 && cnt_wr && bus_wdata == {16'h0, UNL_LO}) half <= 2'd2;
      else                                                     half <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ulk <= 1'b0; rcs <= 1'b1; wleft <= '0;
    end else if (unlock_ok) begin
      ulk <= 1'b1; rcs <= 1'b0; wleft <= WCW'(UNLOCK_CYCLES);
    end else if (cs_wr) begin
      ulk <= 1'b0; rcs <= 1'b1;
    end else if (ulk) begin
      if (wleft <= WCW'(1)) ulk <= 1'b0;
      wleft <= wleft - WCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd32 <= 1'b0; pres <= 1'b0; src <= 2'd0; en <= 1'b0; ie <= 1'b0; upd <= 1'b1;
      toval <= 16'hFFFF; win <= 16'h0;
    end else begin
      if (cs_wr) begin
        cmd32 <= bus_wdata[13]; pres <= bus_wdata[12]; src <= bus_wdata[9:8];
        en <= bus_wdata[7]; ie <= bus_wdata[6]; upd <= bus_wdata[5];
      end
      if (bus_we && ulk && bus_addr == A_TOV) toval <= bus_wdata[15:0];
      if (bus_we && ulk && bus_addr == A_WIN) win <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 16'h0; pre_cnt <= '0; flg <= 1'b0; wdog_rst_o <= 1'b0;
    end else begin
      if (refresh_ok)                    pre_cnt <= '0;
      else if (en && sel_tick && pres && !wdog_rst_o)
        pre_cnt <= pre_wrap ? '0 : pre_cnt + PW'(1);
      if (early) begin
        flg <= 1'b1; wdog_rst_o <= 1'b1;
      end else if (refresh_ok) begin
        cnt <= 16'h0;
      end else if (expire) begin
        cnt <= toval; flg <= 1'b1; wdog_rst_o <= 1'b1;
      end else begin
        if (step) cnt <= cnt + 16'd1;
        if (cs_any && bus_wdata[14]) flg <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CS:    bus_rdata = {17'h0, flg, cmd32, pres, ulk, rcs, src, en, ie, upd, 5'h0};
      A_CNT:   bus_rdata = {16'h0, cnt};
      A_TOV:   bus_rdata = {16'h0, toval};
      A_WIN:   bus_rdata = {16'h0, win};
      default: bus_rdata = 32'h0;
    endcase
  end

  AST_LOCKED_TOV: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_TOV && !ulk) |=> $stable(toval)); // R4
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> wdog_rst_o); // R7
  AST_RST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst_o) |-> flg); // R7
  AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulk) |-> $past(cnt_wr && upd)); // R11
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie); // R8
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0, tick_in = 4'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata, rd;
  logic irq_o, wdog_rst_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  keyed_wdog #(.UNLOCK_CYCLES(128), .PRE_DIV(4), .WARN_TICKS(4)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_in(tick_in), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o));

  // {first word, second word, expected unlocked}
  localparam logic [32:0] VEC [6] = '{
    {16'hC520, 16'hD928, 1'b1}, {16'hD928, 16'hC520, 1'b0}, {16'hC520, 16'hA602, 1'b0},
    {16'hA602, 16'hB480, 1'b0}, {16'hC520, 16'hC520, 1'b0}, {16'hA602, 16'hD928, 1'b0}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdr(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      tick_in[s] = 1'b1; @(negedge clk);
      tick_in[s] = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic unlock16(); wr(4'h4, 32'hC520); wr(4'h4, 32'hD928); endtask
  task automatic ref16();    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480); endtask

  task automatic cfg(input logic [15:0] tov, input logic [15:0] w, input logic [31:0] cs);
    unlock16(); wr(4'h8, {16'h0, tov}); wr(4'hC, {16'h0, w}); wr(4'h0, cs);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rdr(4'h0, rd); chk("R1 cs reset", rd, 32'h420);
    rdr(4'h4, rd); chk("R1 cnt reset", rd, 32'h0);
    rdr(4'h8, rd); chk("R1 toval reset", rd, 32'hFFFF);
    rdr(4'hC, rd); chk("R1 win reset", rd, 32'h0);
    chk("R1 outputs", {30'h0, irq_o, wdog_rst_o}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(4'h4, {16'h0, VEC[i][32:17]}); wr(4'h4, {16'h0, VEC[i][16:1]});
      rdr(4'h0, rd); chk($sformatf("R2 vector %0d", i), {31'h0, rd[11]}, {31'h0, VEC[i][0]});
    end

    do_reset(); unlock16();
    rdr(4'h0, rd); chk("R2 unlocked, not reconfigured", rd, 32'h820);
    repeat (100) @(negedge clk);
    rdr(4'h0, rd); chk("R4 window still open", {31'h0, rd[11]}, 32'h1);
    repeat (40) @(negedge clk);
    rdr(4'h0, rd); chk("R4 window expired", rd, 32'h020);

    do_reset(); wr(4'h4, 32'hC520); wr(4'hC, 32'h7); wr(4'h4, 32'hD928);
    rdr(4'h0, rd); chk("R2 interleaved write breaks sequence", {31'h0, rd[11]}, 32'h0);
    rdr(4'hC, rd); chk("R4 locked window write ignored", rd, 32'h0);
    wr(4'h4, 32'hD928C520);
    rdr(4'h0, rd); chk("R2 32-bit word in 16-bit mode", rd, 32'h420);

    do_reset(); cfg(16'd10, 16'd0, 32'h1E0);
    rdr(4'h0, rd); chk("R4 cs write closes lock", rd, 32'h5E0);
    wr(4'h8, 32'h5);
    rdr(4'h8, rd); chk("R4 locked toval write ignored", rd, 32'd10);
    tick(0, 3);
    rdr(4'h4, rd); chk("R5 unselected source ignored", rd, 32'd0);
    tick(1, 5);
    rdr(4'h4, rd); chk("R5 count", rd, 32'd5);
    chk("R8 irq low before warning", {31'h0, irq_o}, 32'h0);
    tick(1, 1);
    chk("R8 irq at warning", {31'h0, irq_o}, 32'h1);
    ref16();
    rdr(4'h4, rd); chk("R6 refresh zeroes count", rd, 32'd0);
    chk("R8 irq cleared by refresh", {31'h0, irq_o}, 32'h0);
    tick(1, 9);
    chk("R7 no reset before timeout", {31'h0, wdog_rst_o}, 32'h0);
    tick(1, 1);
    chk("R7 reset at timeout", {31'h0, wdog_rst_o}, 32'h1);
    rdr(4'h0, rd); chk("R7 flag set", rd, 32'h45E0);
    wr(4'h0, 32'h4000);
    rdr(4'h0, rd); chk("R9 flag cleared while locked", rd, 32'h5E0);
    chk("R7 reset stays high", {31'h0, wdog_rst_o}, 32'h1);
    ref16();
    rdr(4'h4, rd); chk("R7 refresh ignored after timeout", rd, 32'd10);

    do_reset(); cfg(16'd100, 16'd0, 32'h11A0);
    tick(1, 8);
    rdr(4'h4, rd); chk("R12 prescaled count", rd, 32'd2);
    tick(1, 3);
    rdr(4'h4, rd); chk("R12 partial prescale", rd, 32'd2);
    tick(1, 1);
    rdr(4'h4, rd); chk("R12 prescale wrap", rd, 32'd3);

    do_reset(); cfg(16'd20, 16'd5, 32'h1A0);
    tick(1, 6); ref16();
    rdr(4'h4, rd); chk("R10 refresh inside window", rd, 32'd0);
    chk("R10 no reset inside window", {31'h0, wdog_rst_o}, 32'h0);
    tick(1, 2); ref16();
    chk("R10 early refresh resets", {31'h0, wdog_rst_o}, 32'h1);
    rdr(4'h0, rd); chk("R10 early refresh flag", {31'h0, rd[14]}, 32'h1);

    do_reset(); cfg(16'd100, 16'd0, 32'h21A0);
    rdr(4'h0, rd); chk("R3 32-bit mode set", rd, 32'h25A0);
    tick(1, 3); ref16();
    rdr(4'h4, rd); chk("R3 16-bit refresh ignored", rd, 32'd3);
    wr(4'h4, 32'hB480A602);
    rdr(4'h4, rd); chk("R3 32-bit refresh", rd, 32'd0);
    unlock16();
    rdr(4'h0, rd); chk("R3 16-bit unlock ignored", {31'h0, rd[11]}, 32'h0);
    wr(4'h4, 32'hD928C520);
    rdr(4'h0, rd); chk("R3 32-bit unlock", {31'h0, rd[11]}, 32'h1);

    do_reset(); cfg(16'd100, 16'd0, 32'h180);
    rdr(4'h0, rd); chk("R11 update bit cleared", rd, 32'h580);
    unlock16();
    rdr(4'h0, rd); chk("R11 unlock rejected", rd, 32'h580);
    wr(4'h8, 32'h5);
    rdr(4'h8, rd); chk("R11 toval kept", rd, 32'd100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule